// File: doc/BRIEF.md
# Byte-Wide Host to Word-Wide IDE Register Bridge

This block lets a host with an 8-bit I/O bus drive a disk interface whose task-file data register is 16 bits wide. It claims a window of sixteen consecutive I/O ports. Most ports map one-to-one onto a device register. One extra port gives the host direct access to a holding register for the upper data byte, so one 16-bit data word moves as two byte accesses.

To write a word, the host first stores the upper byte in the holding register, then writes the lower byte to the data port. The bridge then issues one 16-bit device write. To read a word, the host reads the data port. The bridge performs one 16-bit device read, returns the lower byte and keeps the upper byte in the holding register, which the host then reads. Every host access is registered once before it reaches the device. The device answer is captured one cycle later.

Top module: `ide_byte_bridge`

## Requirements
- R1: The window covers ports BASE to BASE+15. BASE is 0x300 when `alt_base` is 0 and 0x360 when `alt_base` is 1. An access outside the window causes no device strobe and leaves `host_rdata` unchanged.
- R2: A host write to offset 0 causes one device write to command register 0 with `dev_wdata` = {holding register, host byte}. The strobe is high in the cycle after the clock edge that sampled the host write.
- R3: A host read of offset 0 causes one device read of command register 0. The next edge loads the low byte of the device word into `host_rdata` and the high byte into the holding register.
- R4: Offsets 1 to 7 access command registers 1 to 7 (`dev_reg` = offset). Writes carry the host byte with `dev_wdata[15:8]` = 0. Reads return `dev_rdata[7:0]`, and the holding register is not changed.
- R5: A write to offset 8 loads the holding register. A read of offset 8 returns it. Neither causes a device strobe.
- R6: Offset 0xE accesses the control block: `dev_cs_ctl` is 1, `dev_cs_cmd` is 0 and `dev_reg` = 6, for both reads and writes.
- R7: A read of offset 9 to 0xD or 0xF returns 0xFF. A write to those offsets causes no strobe and changes no state.
- R8: After reset, the holding register and `host_rdata` are 0 and no device strobe is active.
- R9: Each mapped host access gives exactly one device strobe, one cycle long. `dev_wr` and `dev_rd` are never high together, and an active strobe always has exactly one of the two selects set.
- R10: Host accesses on back-to-back cycles are handled correctly. Loading offset 8 and then writing offset 0 in the next cycle writes the new upper byte. Writing offset 0 before loading offset 8 writes the old upper byte. Reading offset 8 before offset 0 returns the old upper byte.
- R11: If `host_wr` and `host_rd` are high in the same cycle, the access is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alt_base | input | 1 | Selects the alternative window base |
| host_addr | input | 10 | Host I/O port address |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid from the second edge after the request |
| dev_cs_cmd | output | 1 | Command-block select |
| dev_cs_ctl | output | 1 | Control-block select |
| dev_reg | output | 3 | Device register index |
| dev_wr | output | 1 | Device write strobe |
| dev_rd | output | 1 | Device read strobe |
| dev_wdata | output | 16 | Device write word |
| dev_rdata | input | 16 | Device read word, sampled while `dev_rd` is high |

## Verification
The host strobe is sampled at edge E0. The device strobe, select, index and write word are then valid between E0 and E1. Read results, in both `host_rdata` and the holding register, are present after E1. The bench drives inputs on falling edges. It checks device-side values at the falling edge after E0 and `host_rdata` at the falling edge after E1, and counts strobes on every rising edge to confirm the exact number per access. Back-to-back accesses use the same timing, so the ordering cases check that the holding register updated at one edge is used by the device write issued at that same edge.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;
  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_DATA  = 3'd1,
    K_CMD   = 3'd2,
    K_HOLD  = 3'd3,
    K_CTL   = 3'd4
  } acc_kind_t;

  localparam logic [3:0] OFF_DATA = 4'h0;
  localparam logic [3:0] OFF_HOLD = 4'h8;
  localparam logic [3:0] OFF_CTL  = 4'hE;
  localparam logic [2:0] CTL_IDX  = 3'd6;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/ide_bridge_decode.sv
module ide_bridge_decode
  import ide_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned BASE     = 'h300,
  parameter int unsigned ALT_BASE = 'h360
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              alt_sel,
  output logic              hit,
  output acc_kind_t         kind,
  output logic [2:0]        reg_idx
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] ALT_V  = ADDR_W'(ALT_BASE);

  logic [ADDR_W-1:0] base_sel;
  logic [3:0]        off;

  always_comb begin
    base_sel = alt_sel ? ALT_V : BASE_V;
    off      = addr[3:0];
    hit      = (addr[ADDR_W-1:4] == base_sel[ADDR_W-1:4]);
    reg_idx  = off[2:0];
    if (off == OFF_DATA)      kind = K_DATA;
    else if (off < OFF_HOLD)  kind = K_CMD;
    else if (off == OFF_HOLD) kind = K_HOLD;
    else if (off == OFF_CTL)  kind = K_CTL;
    else                      kind = K_NONE;
    if (off == OFF_CTL)       reg_idx = CTL_IDX;
  end
endmodule

// File: rtl/ide_bridge_req.sv
module ide_bridge_req
  import ide_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic        hit,
  input  acc_kind_t   kind,
  input  logic [2:0]  reg_idx,
  input  logic [7:0]  host_wdata,
  output logic        s1_valid,
  output logic        s1_wr,
  output acc_kind_t   s1_kind,
  output logic [2:0]  s1_reg,
  output logic [7:0]  s1_wdata
);
  logic       acc;
  logic       valid_n;
  logic       wr_n;
  acc_kind_t  kind_n;
  logic [2:0] reg_n;
  logic [7:0] wdata_n;

  always_comb begin
    acc     = hit && (host_wr || host_rd);
    valid_n = acc;
    wr_n    = s1_wr;
    kind_n  = s1_kind;
    reg_n   = s1_reg;
    wdata_n = s1_wdata;
    if (acc) begin
      wr_n    = host_wr;
      kind_n  = kind;
      reg_n   = reg_idx;
      wdata_n = host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_wr    <= 1'b0;
      s1_kind  <= K_NONE;
      s1_reg   <= 3'd0;
      s1_wdata <= 8'h00;
    end else begin
      s1_valid <= valid_n;
      if (acc) begin
        s1_wr    <= wr_n;
        s1_kind  <= kind_n;
        s1_reg   <= reg_n;
        s1_wdata <= wdata_n;
      end
    end
  end
endmodule

// File: rtl/ide_bridge_resp.sv
module ide_bridge_resp
  import ide_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s1_valid,
  input  logic        s1_wr,
  input  acc_kind_t   s1_kind,
  input  logic [7:0]  s1_wdata,
  input  logic [15:0] dev_rdata,
  output logic [7:0]  hold_q,
  output logic [7:0]  host_rdata
);
  logic       rd_en;
  logic       hold_en;
  logic [7:0] hold_n;
  logic [7:0] rdata_n;

  always_comb begin
    rd_en   = s1_valid && !s1_wr;
    hold_en = 1'b0;
    hold_n  = hold_q;
    unique case (s1_kind)
      K_DATA, K_CMD, K_CTL: rdata_n = dev_rdata[7:0];
      K_HOLD:               rdata_n = hold_q;
      default:              rdata_n = IDLE_BYTE;
    endcase
    if (s1_valid && s1_wr && s1_kind == K_HOLD) begin
      hold_en = 1'b1;
      hold_n  = s1_wdata;
    end else if (rd_en && s1_kind == K_DATA) begin
      hold_en = 1'b1;
      hold_n  = dev_rdata[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= 8'h00;
      host_rdata <= 8'h00;
    end else begin
      if (hold_en) hold_q     <= hold_n;
      if (rd_en)   host_rdata <= rdata_n;
    end
  end
endmodule

// File: rtl/ide_byte_bridge.sv
module ide_byte_bridge
  import ide_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned BASE     = 'h300,
  parameter int unsigned ALT_BASE = 'h360
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_base,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              dev_cs_cmd,
  output logic              dev_cs_ctl,
  output logic [2:0]        dev_reg,
  output logic              dev_wr,
  output logic              dev_rd,
  output logic [15:0]       dev_wdata,
  input  logic [15:0]       dev_rdata
);
  logic       hit;
  acc_kind_t  kind;
  logic [2:0] reg_idx;
  logic       s1_valid;
  logic       s1_wr;
  acc_kind_t  s1_kind;
  logic [2:0] s1_reg;
  logic [7:0] s1_wdata;
  logic [7:0] hold_q;
  logic       dev_act;

  ide_bridge_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .ALT_BASE(ALT_BASE)) u_dec (
    .addr(host_addr), .alt_sel(alt_base), .hit(hit), .kind(kind), .reg_idx(reg_idx)
  );

  ide_bridge_req u_req (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd), .hit(hit),
    .kind(kind), .reg_idx(reg_idx), .host_wdata(host_wdata), .s1_valid(s1_valid),
    .s1_wr(s1_wr), .s1_kind(s1_kind), .s1_reg(s1_reg), .s1_wdata(s1_wdata)
  );

  ide_bridge_resp u_resp (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_wr(s1_wr), .s1_kind(s1_kind),
    .s1_wdata(s1_wdata), .dev_rdata(dev_rdata), .hold_q(hold_q), .host_rdata(host_rdata)
  );

  always_comb begin
    dev_act    = s1_valid && (s1_kind == K_DATA || s1_kind == K_CMD || s1_kind == K_CTL);
    dev_wr     = dev_act && s1_wr;
    dev_rd     = dev_act && !s1_wr;
    dev_cs_ctl = dev_act && (s1_kind == K_CTL);
    dev_cs_cmd = dev_act && (s1_kind != K_CTL);
    dev_reg    = s1_reg;
    dev_wdata  = (s1_kind == K_DATA) ? {hold_q, s1_wdata} : {8'h00, s1_wdata};
  end
endmodule

// File: rtl/ide_byte_bridge_chk.sv
module ide_byte_bridge_chk #(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned BASE     = 'h300,
  parameter int unsigned ALT_BASE = 'h360
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alt_base,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic [7:0]        host_wdata,
  input logic [7:0]        host_rdata,
  input logic              dev_cs_cmd,
  input logic              dev_cs_ctl,
  input logic [2:0]        dev_reg,
  input logic              dev_wr,
  input logic              dev_rd,
  input logic [15:0]       dev_wdata
);
  localparam logic [ADDR_W-1:0] B0 = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] B1 = ADDR_W'(ALT_BASE);

  logic       win;
  logic [3:0] off;
  logic       quiet_off;
  logic       host_acc;

  always_comb begin
    win       = host_addr[ADDR_W-1:4] == (alt_base ? B1[ADDR_W-1:4] : B0[ADDR_W-1:4]);
    off       = host_addr[3:0];
    quiet_off = (off >= 4'h8) && (off != 4'hE);
    host_acc  = host_wr || host_rd;
  end

  // R2 data write forwarded with host low byte
  p_data_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && win && off == 4'h0) |=>
      (dev_wr && dev_cs_cmd && dev_reg == 3'd0 && dev_wdata[7:0] == $past(host_wdata)));

  // R4 command reads reach the matching register
  p_cmd_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && win && off != 4'h0 && off < 4'h8) |=>
      (dev_rd && dev_cs_cmd && dev_reg == $past(host_addr[2:0])));

  // R5 R7 R1 no device activity for quiet offsets or outside the window
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_acc && (!win || quiet_off)) |=> !(dev_wr || dev_rd));

  // R7 unmapped reads give the idle byte
  p_idle_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && win && quiet_off && off != 4'h8) |=> ##1 (host_rdata == 8'hFF));

  // R6 control accesses use index 6 and only the control select
  p_ctl_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((dev_wr || dev_rd) && dev_cs_ctl) |-> (dev_reg == 3'd6 && !dev_cs_cmd));

  // R9 strobes are exclusive and carry exactly one select
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_wr && dev_rd));
  p_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr || dev_rd) |-> $onehot({dev_cs_cmd, dev_cs_ctl}));

  // R11 simultaneous strobes act as a write
  p_wr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_rd && win && !quiet_off) |=> (dev_wr && !dev_rd));
endmodule

bind ide_byte_bridge ide_byte_bridge_chk #(.ADDR_W(ADDR_W), .BASE(BASE), .ALT_BASE(ALT_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .alt_base(alt_base), .host_addr(host_addr), .host_wr(host_wr),
  .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata), .dev_cs_cmd(dev_cs_cmd),
  .dev_cs_ctl(dev_cs_ctl), .dev_reg(dev_reg), .dev_wr(dev_wr), .dev_rd(dev_rd),
  .dev_wdata(dev_wdata)
);

// File: tb/sim_ide_byte_bridge.sv
`timescale 1ns/1ps
module sim_ide_byte_bridge;
  logic        clk;
  logic        rst_n;
  logic        alt_base;
  logic [9:0]  host_addr;
  logic        host_wr;
  logic        host_rd;
  logic [7:0]  host_wdata;
  logic [7:0]  host_rdata;
  logic        dev_cs_cmd;
  logic        dev_cs_ctl;
  logic [2:0]  dev_reg;
  logic        dev_wr;
  logic        dev_rd;
  logic [15:0] dev_wdata;
  logic [15:0] dev_rdata;

  int errors = 0;
  int checks = 0;
  int strobes = 0;
  bit done = 0;

  ide_byte_bridge u0 (.*);

  initial clk = 0;
  always #2 clk = ~clk;

  // device register model
  logic [15:0] m_data;
  logic [7:0]  m_cmd [1:7];
  logic [7:0]  m_ctl;

  always_comb begin
    if (dev_cs_ctl)                       dev_rdata = {8'hA5, m_ctl};
    else if (dev_cs_cmd && dev_reg == 0)  dev_rdata = m_data;
    else if (dev_cs_cmd)                  dev_rdata = {8'h5A, m_cmd[dev_reg]};
    else                                  dev_rdata = 16'hDEAD;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data <= 16'h0;
      m_ctl  <= 8'h0;
      for (int i = 1; i < 8; i++) m_cmd[i] <= 8'h0;
    end else begin
      if (dev_wr || dev_rd) strobes <= strobes + 1;
      if (dev_wr) begin
        if (dev_cs_ctl)          m_ctl <= dev_wdata[7:0];
        else if (dev_reg == 0)   m_data <= dev_wdata;
        else                     m_cmd[dev_reg] <= dev_wdata[7:0];
      end
    end
  end

  // shadow of expected state
  logic [7:0]  e_hold;
  logic [15:0] e_data;
  logic [7:0]  e_cmd [1:7];
  logic [7:0]  e_ctl;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit maps(input logic [3:0] off);
    return (off < 4'h8) || (off == 4'hE);
  endfunction

  function automatic logic [7:0] exp_read(input logic [3:0] off);
    if (off == 0) return e_data[7:0];
    if (off < 8) return e_cmd[off[2:0]];
    if (off == 8) return e_hold;
    if (off == 4'hE) return e_ctl;
    return 8'hFF;
  endfunction

  task automatic shadow_write(input logic [3:0] off, input logic [7:0] v);
    if (off == 0) e_data = {e_hold, v};
    else if (off < 8) e_cmd[off[2:0]] = v;
    else if (off == 8) e_hold = v;
    else if (off == 4'hE) e_ctl = v;
  endtask

  function automatic logic [9:0] base();
    return alt_base ? 10'h360 : 10'h300;
  endfunction

  // single write; checks device-side values while the strobe is active
  task automatic hwrite(input logic [3:0] off, input logic [7:0] v);
    int s0;
    @(negedge clk);
    s0 = strobes;
    host_addr = base() + off; host_wdata = v; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
    if (off == 0)      chk("R2 data word", dev_wdata, {e_hold, v});
    else if (off < 8)  chk("R4 byte write", {dev_reg, 5'd0, dev_wdata[15:8]}, {off[2:0], 13'd0});
    else if (off == 4'hE) chk("R6 ctl sel", {dev_cs_ctl, dev_cs_cmd, dev_reg}, {2'b10, 3'd6});
    @(negedge clk);
    chk("R9 strobe count (write)", strobes - s0, maps(off) ? 1 : 0);
    shadow_write(off, v);
  endtask

  task automatic hread(input logic [3:0] off);
    int s0;
    @(negedge clk);
    s0 = strobes;
    host_addr = base() + off; host_rd = 1;
    @(negedge clk);
    host_rd = 0;
    @(negedge clk);
    chk(off == 0 ? "R3 data low byte" : off == 8 ? "R5 hold read" :
        maps(off) ? "R4 R6 byte read" : "R7 idle byte", host_rdata, exp_read(off));
    chk("R9 strobe count (read)", strobes - s0, maps(off) ? 1 : 0);
    if (off == 0) e_hold = e_data[15:8];
  endtask

  task automatic outside(input logic [9:0] a, input bit wr);
    int s0; logic [7:0] prev;
    @(negedge clk);
    s0 = strobes; prev = host_rdata;
    host_addr = a; host_wdata = 8'h77; host_wr = wr; host_rd = !wr;
    @(negedge clk);
    host_wr = 0; host_rd = 0;
    @(negedge clk);
    chk("R1 outside window no strobe", strobes - s0, 0);
    chk("R1 outside window rdata held", host_rdata, prev);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; alt_base = 0; host_addr = 0; host_wr = 0; host_rd = 0; host_wdata = 0;
    e_hold = 0; e_data = 0; e_ctl = 0;
    for (int i = 1; i < 8; i++) e_cmd[i] = 0;
    void'($urandom(32'h1D3));
    repeat (3) @(negedge clk);
    chk("R8 reset rdata", host_rdata, 8'h00);
    chk("R8 reset strobes", {dev_wr, dev_rd}, 2'b00);
    rst_n = 1;
    hread(4'h8); // R8 hold is zero

    // R10 ordered word write, back to back
    @(negedge clk);
    host_addr = 10'h308; host_wdata = 8'h11; host_wr = 1;
    @(negedge clk);
    host_addr = 10'h300; host_wdata = 8'h22;
    @(negedge clk);
    host_wr = 0;
    @(negedge clk);
    chk("R10 ordered write word", m_data, 16'h1122);
    e_hold = 8'h11; e_data = 16'h1122;
    // R10 wrong order writes the old upper byte
    hwrite(4'h0, 8'h33);
    hwrite(4'h8, 8'h44);
    chk("R10 stale upper byte", m_data, 16'h1133);
    // R10 read hold before data gives stale value, then proper order
    hread(4'h8);
    chk("R10 stale hold read", host_rdata, 8'h44);
    @(negedge clk);
    host_addr = 10'h300; host_rd = 1;
    @(negedge clk);
    host_addr = 10'h308;
    @(negedge clk);
    host_rd = 0;
    chk("R3 low byte back to back", host_rdata, 8'h33);
    @(negedge clk);
    chk("R10 ordered read upper", host_rdata, 8'h11);
    e_hold = 8'h11;

    // R4 command byte read must not touch hold
    hwrite(4'h3, 8'h9C);
    hread(4'h3);
    hread(4'h8);
    // R6 control
    hwrite(4'hE, 8'h0C);
    hread(4'hE);
    // R7 unmapped write then read
    hwrite(4'hB, 8'h55);
    hread(4'hB);
    hread(4'h8);

    // R11 simultaneous strobes act as write
    begin
      int s0;
      @(negedge clk);
      s0 = strobes;
      host_addr = 10'h305; host_wdata = 8'h6E; host_wr = 1; host_rd = 1;
      @(negedge clk);
      host_wr = 0; host_rd = 0;
      chk("R11 write wins", {dev_wr, dev_rd}, 2'b10);
      @(negedge clk);
      chk("R11 one strobe", strobes - s0, 1);
      e_cmd[5] = 8'h6E;
      hread(4'h5);
    end

    // R1 outside window and alternative base
    outside(10'h310, 0);
    outside(10'h2FF, 1);
    outside(10'h361, 0);
    alt_base = 1;
    outside(10'h301, 0);
    hwrite(4'h2, 8'hB7);
    hread(4'h2);
    alt_base = 0;
    hread(4'h2);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [3:0] off; bit wr;
      off = 4'($urandom_range(0, 15));
      wr = $urandom_range(0, 1) == 1;
      alt_base = $urandom_range(0, 3) == 0;
      if ($urandom_range(0, 15) == 0) outside(10'h100 + 10'($urandom_range(0, 255)), wr);
      else if (wr) hwrite(off, 8'($urandom()));
      else hread(off);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule